// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block is a direct-mapped cache placed between a processor-side port, which reads and writes single words, and a main-memory port one word wide. A 16-bit word address is split into a tag, a line index and a word offset. The cache has 128 lines of 16 words. Memory line `j`, which is address bits [15:4], can only live in cache line `j mod 128`. A request is a hit only when the indexed line is filled and its stored tag equals the address tag. A hit completes in the cycle it is presented.

On a miss, reads and writes are treated alike (write-allocate). If the resident line is filled and modified, it is first copied back to memory one word at a time. The addressed memory line is then loaded one word at a time, and the request is then served from the freshly loaded line. Any write marks its line as different from memory. Memory is updated only when such a line is evicted.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_ready` is seen high. On the memory side, `mem_req` is held with a steady address, direction and write data until `mem_ack` is seen at a clock edge. One `mem_ack` moves exactly one word.

Top module: `dm_wb_cache`

## Requirements
- R1: The address decodes as tag = bits [15:11], line index = bits [10:4] and word offset = bits [3:0]. Address 0x357A is tag 6, line 87, word 10, and its miss loads memory line 855 starting at word address 0x3570.
- R2: A request hits only if the indexed line is filled and its stored tag equals the address tag. A hit raises `cpu_ready` and `cpu_hit` in the cycle the request is presented, with no memory traffic.
- R3: A read returns the value most recently written by the processor to that address, or else the memory contents of that address.
- R4: A write hit changes only the addressed word and marks the line modified.
- R5: A miss on an empty or unmodified line makes exactly 16 memory reads, at {addr[15:4], 0..15} in ascending order, and no memory write.
- R6: A miss on a modified line first makes exactly 16 memory writes of the resident line, at {stored tag, index, 0..15} in ascending order, before the first memory read. The written data are the line's current words.
- R7: A write miss loads the line, then replaces only the addressed word. The other 15 words keep their memory values, and the line is marked modified.
- R8: After reset every line is empty and the memory port is idle. The first access to any line misses without a write-back.
- R9: `mem_req` stays high with a steady `mem_addr` and `mem_we` until `mem_ack` is seen. Each acknowledge transfers one word.
- R10: `cpu_ready` is high only while `cpu_req` is high and the memory port is idle. `cpu_hit` is low on completion of an access that needed a line load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Completing access needed no line load |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = load word |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write-back data |
| mem_rdata | input | DW | Load data, valid with mem_ack |
| mem_ack | input | 1 | Memory has taken or supplied the word |

## Verification
The bench keeps its own model of which tag each line holds and whether it is filled or modified. It drives same-index conflicts so that modified victims alternate with clean ones. A design that skipped the write-back would lose data, which shows up on a later read from memory. A design that wrote back clean lines would show 16 unexpected writes. One that used the new tag for write-back addresses would corrupt the wrong memory line. A sweep over all 128 lines with write misses, hits, dirty evictions and re-reads targets three faults: index-decode errors, which would alias lines; partial updates after a load, which would clobber neighbouring words; and valid bits not cleared at reset, which would produce false hits.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int TAG_W = 5,
  parameter int IDX_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          cpu_hit,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int OFF_W = AW - TAG_W - IDX_W;
  localparam int LINES = 2 ** IDX_W;
  localparam int WORDS = 2 ** OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_WBACK, S_FILL} state_t;

  state_t                 st;
  logic [OFF_W-1:0]       cnt;
  logic                   refilled;
  logic [LINES-1:0]       vld;
  logic [LINES-1:0]       dty;
  logic [TAG_W-1:0]       tag_mem [LINES];
  logic [DW-1:0]          dat     [LINES*WORDS];

  logic [TAG_W-1:0]       a_tag;
  logic [IDX_W-1:0]       a_idx;
  logic [OFF_W-1:0]       a_off;
  logic                   hit;
  logic                   last;

  assign a_tag = cpu_addr[AW-1 -: TAG_W];
  assign a_idx = cpu_addr[OFF_W +: IDX_W];
  assign a_off = cpu_addr[OFF_W-1:0];
  assign hit   = vld[a_idx] && (tag_mem[a_idx] == a_tag);
  assign last  = (cnt == OFF_W'(WORDS - 1));

  assign cpu_ready = (st == S_IDLE) && cpu_req && hit;
  assign cpu_hit   = cpu_ready && !refilled;
  assign cpu_rdata = dat[{a_idx, a_off}];

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WBACK);
  assign mem_addr  = (st == S_WBACK) ? {tag_mem[a_idx], a_idx, cnt} : {a_tag, a_idx, cnt};
  assign mem_wdata = dat[{a_idx, cnt}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      refilled <= 1'b0;
      vld      <= '0;
      dty      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cpu_ready) begin
            refilled <= 1'b0;
            if (cpu_we) dty[a_idx] <= 1'b1;
          end else if (cpu_req) begin
            cnt <= '0;
            st  <= (vld[a_idx] && dty[a_idx]) ? S_WBACK : S_FILL;
          end
        end
        S_WBACK: begin
          if (mem_ack) begin
            cnt <= cnt + OFF_W'(1);
            if (last) st <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            cnt <= cnt + OFF_W'(1);
            if (last) begin
              vld[a_idx] <= 1'b1;
              dty[a_idx] <= 1'b0;
              refilled   <= 1'b1;
              st         <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_ready && cpu_we)
      dat[{a_idx, a_off}] <= cpu_wdata;
    else if (st == S_FILL && mem_ack)
      dat[{a_idx, cnt}] <= mem_rdata;
    if (st == S_FILL && mem_ack && last)
      tag_mem[a_idx] <= a_tag;
  end
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int TAG_W = 5,
  parameter int IDX_W = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          cpu_ready,
  input logic          cpu_hit,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_ack
);
  localparam int OFF_W = AW - TAG_W - IDX_W;

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_req && !mem_req));

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (cpu_ready && !mem_req));

  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_fill_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[AW-1:OFF_W] == cpu_addr[AW-1:OFF_W]));

  p_wb_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_addr[OFF_W +: IDX_W] == cpu_addr[OFF_W +: IDX_W]) &&
                             (mem_addr[AW-1 -: TAG_W] != cpu_addr[AW-1 -: TAG_W])));

  p_no_wb_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !(mem_req && mem_we));

  p_mem_needs_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_req);
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.AW(AW), .DW(DW), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_dm_wb_cache.sv
module tb_dm_wb_cache;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_ready;
  logic        cpu_hit;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dm_wb_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input logic [15:0] a);
    return (a * 16'd40503) ^ 16'h5A5A;
  endfunction

  logic [15:0] memw [int];
  logic [15:0] shadow [int];
  logic [15:0] wb_log [16];
  logic [15:0] wbd_log [16];
  logic [15:0] rd_log [16];
  int wb_n = 0;
  int rd_n = 0;
  bit order_bad = 0;
  logic [15:0] last_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack)
        chk(mem_addr == last_addr, "R9", "address held through acknowledge", mem_addr, last_addr);
      if (mem_req && !mem_ack) begin
        last_addr <= mem_addr;
        if (mem_we) begin
          memw[int'(mem_addr)] = mem_wdata;
          if (rd_n > 0) order_bad = 1;
          if (wb_n < 16) begin wb_log[wb_n] = mem_addr; wbd_log[wb_n] = mem_wdata; end
          wb_n++;
        end else begin
          mem_rdata <= memw.exists(int'(mem_addr)) ? memw[int'(mem_addr)] : init_val(mem_addr);
          if (rd_n < 16) rd_log[rd_n] = mem_addr;
          rd_n++;
        end
      end
    end
  end

  bit          ev [128];
  logic [4:0]  et [128];
  bit          ed [128];

  function automatic logic [15:0] cpu_view(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  task automatic access(input bit we, input logic [15:0] a, input logic [15:0] wd);
    int idx;
    logic [4:0] tg;
    logic [4:0] old_tag;
    bit exp_hit;
    bit exp_wb;
    int cyc;
    logic [15:0] got;
    bit got_hit;
    logic [15:0] exp_data;
    idx = int'(a[10:4]);
    tg = a[15:11];
    old_tag = et[idx];
    exp_hit = ev[idx] && et[idx] == tg;
    exp_wb = !exp_hit && ev[idx] && ed[idx];
    exp_data = cpu_view(a);
    @(negedge clk);
    wb_n = 0; rd_n = 0; order_bad = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    cyc = 0;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      cyc++;
    end
    got = cpu_rdata;
    got_hit = cpu_hit;
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    chk(cpu_ready == 1'b0, "R10", "ready without request", cpu_ready, 0);
    chk(got_hit == exp_hit, "R2", "hit flag", got_hit, exp_hit);
    if (exp_hit) chk(cyc == 0, "R2", "hit latency", cyc, 0);
    if (!we) chk(got == exp_data, "R3", "read data", got, exp_data);
    chk(wb_n == (exp_wb ? 16 : 0), "R6", "write-back word count", wb_n, exp_wb ? 16 : 0);
    chk(rd_n == (exp_hit ? 0 : 16), "R5", "load word count", rd_n, exp_hit ? 0 : 16);
    chk(order_bad == 0, "R6", "write-back precedes load", order_bad, 0);
    if (exp_wb && wb_n == 16)
      for (int k = 0; k < 16; k++) begin
        chk(wb_log[k] == {old_tag, a[10:4], 4'(k)}, "R6", "write-back address",
            wb_log[k], {old_tag, a[10:4], 4'(k)});
        chk(wbd_log[k] == cpu_view({old_tag, a[10:4], 4'(k)}), "R6", "write-back data",
            wbd_log[k], cpu_view({old_tag, a[10:4], 4'(k)}));
      end
    if (!exp_hit && rd_n == 16)
      for (int k = 0; k < 16; k++)
        chk(rd_log[k] == {a[15:4], 4'(k)}, "R5", "load address", rd_log[k], {a[15:4], 4'(k)});
    if (!exp_hit) begin ev[idx] = 1; et[idx] = tg; ed[idx] = 0; end
    if (we) begin ed[idx] = 1; shadow[int'(a)] = wd; end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin ev[i] = 0; et[i] = 0; ed[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0, "R8", "memory idle after reset", mem_req, 0);
    chk(cpu_ready == 1'b0, "R8", "ready low after reset", cpu_ready, 0);

    chk(16'h357A >> 11 == 6, "R1", "tag of 0x357A", 16'h357A >> 11, 6);
    chk(((16'h357A >> 4) & 16'h7F) == 87, "R1", "line of 0x357A", (16'h357A >> 4) & 16'h7F, 87);
    chk((16'h357A >> 4) == 855, "R1", "memory line of 0x357A", 16'h357A >> 4, 855);
    access(0, 16'h357A, 0);
    chk(rd_log[0] == 16'h3570, "R1", "first load address", rd_log[0], 16'h3570);
    chk(wb_n == 0, "R8", "no write-back from empty line", wb_n, 0);
    access(0, 16'h357A, 0);

    for (int w = 0; w < 16; w++) access(0, {12'h357, 4'(w)}, 0);

    access(1, 16'h3575, 16'hBEEF);
    chk(wb_n == 0 && rd_n == 0, "R4", "write hit no traffic", wb_n + rd_n, 0);
    for (int w = 4; w < 7; w++) access(0, {12'h357, 4'(w)}, 0);

    access(0, 16'h3D7A, 0);
    access(0, 16'h3575, 0);

    access(1, 16'h1234, 16'h1111);
    chk(ed[35] == 1, "R7", "model marks write-miss line modified", ed[35], 1);
    for (int w = 0; w < 16; w++) access(0, {12'h123, 4'(w)}, 0);
    access(0, 16'h9234, 0);
    chk(wb_n == 16, "R7", "write-miss line written back", wb_n, 16);
    access(0, 16'h1234, 0);

    for (int i = 0; i < 128; i++)
      access(1, {5'd3, 7'(i), 4'(i % 16)}, 16'(i * 257 + 1));
    for (int i = 0; i < 128; i++)
      access(0, {5'd3, 7'(i), 4'(i % 16)}, 0);
    for (int i = 0; i < 128; i++)
      access(0, {5'd9, 7'(i), 4'((i + 1) % 16)}, 0);
    for (int i = 0; i < 128; i++)
      access(0, {5'd3, 7'(i), 4'(i % 16)}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule